// File: doc/BRIEF.md
# 31-Bit Tree Population Counter

This block reports how many bits of a 31-bit word are set. It sums the bits in a fixed four-level tree of small adders, so the path length does not depend on how many bits are set.

The first level is a row of eight full adders, one for each group of three input bits. Each of the remaining seven inputs enters a later adder through its carry-in. Inputs 24 to 27 feed the four 2-bit adders of the second level. Inputs 28 and 29 feed the two 3-bit adders of the third level. Input 30 feeds the single 4-bit adder of the last level. No input is padded and no carry-in is wasted, so the tree is full at exactly 31 inputs.

The 5-bit result is either taken straight from the tree or held in an output register, chosen by a parameter.

Top module: `popcnt31_tree`

## Requirements
- R1: `count_o` equals the number of ones in `bits_i` for every input pattern. With `OUT_REG`=1 the count of the word sampled at a rising clock edge appears after that edge. With `OUT_REG`=0 it appears in the same cycle.
- R2: An all-zero input gives a count of 0.
- R3: The all-ones input gives 31 (5'b11111), and no stage overflows on it.
- R4: A word with exactly one set bit gives 1, at every position 0 to 30. This covers the full-adder inputs and each of the carry-in inputs at positions 24 to 30.
- R5: With `OUT_REG`=1, while `rst_n` is low the output register is cleared, and `count_o` is 0 after the next rising edge whatever `bits_i` holds.
- R6: A word whose k lowest bits are set gives k, for each k from 0 to 31. A word whose k lowest bits are clear and the rest set gives 31-k.
- R7: Every adder in the tree returns the exact arithmetic sum of its operands and its carry-in, in a result one bit wider than its operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| bits_i | input | 31 | Word whose set bits are counted |
| count_o | output | 5 | Number of set bits, 0 to 31 |

## Verification
Single set bits at all 31 positions show that each full-adder input and each carry-in input is counted with weight one. Swapping any two inputs of the tree cannot be caught this way, but dropping an input can. Lowest-bit prefixes and their complements step the count through every value from 0 to 31, which exposes a wrong weight or a lost carry between levels, including the overflow-prone all-ones word. Alternating patterns and several thousand random words then check mixed carries inside the tree, on both the registered and the direct variant.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;
   localparam int PC_IN_W    = 31;                  // total input bits
   localparam int PC_FA_N    = 8;                   // level-1 full adders
   localparam int PC_L2_N    = PC_FA_N / 2;         // level-2 adders
   localparam int PC_L3_N    = PC_L2_N / 2;         // level-3 adders
   localparam int PC_L2_BASE = 3 * PC_FA_N;         // first carry-in bit, level 2
   localparam int PC_L3_BASE = PC_L2_BASE + PC_L2_N;
   localparam int PC_L4_BIT  = PC_L3_BASE + PC_L3_N;
   localparam int PC_OUT_W   = $clog2(PC_IN_W + 1);
endpackage

// File: rtl/popcnt_fa3.sv
module popcnt_fa3 (
   input  logic [2:0] trio_i,
   output logic [1:0] sum_o
);
   logic s, c;
   always_comb begin
      s = trio_i[0] ^ trio_i[1] ^ trio_i[2];
      c = (trio_i[0] & trio_i[1]) | (trio_i[2] & (trio_i[0] ^ trio_i[1]));
      sum_o = {c, s};
   end

   // R7
   always_comb begin
      fa_sum_chk: assert (sum_o == 2'(trio_i[0]) + 2'(trio_i[1]) + 2'(trio_i[2]))
         else $error("full adder miscount");
   end
endmodule

// File: rtl/popcnt_rca.sv
module popcnt_rca #(
   parameter int W = 2
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W:0]   sum_o
);
   if (W < 1) begin : g_bad_w
      $error("popcnt_rca: W must be at least 1");
   end

   logic [W:0] carry;
   assign carry[0] = cin_i;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum_o[i]    = a_i[i] ^ b_i[i] ^ carry[i];
      assign carry[i+1]  = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
   end
   assign sum_o[W] = carry[W];

   // R7
   always_comb begin
      no_overflow_chk: assert (sum_o == (W+1)'(a_i) + (W+1)'(b_i) + (W+1)'(cin_i))
         else $error("ripple adder result wrong or overflowed");
   end
endmodule

// File: rtl/popcnt31_tree.sv
module popcnt31_tree
   import popcnt_pkg::*;
#(
   parameter int IN_W    = 31,
   parameter bit OUT_REG = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [30:0] bits_i,
   output logic [4:0]  count_o
);
   localparam int OUT_W = $clog2(IN_W + 1);

   if (IN_W != PC_IN_W) begin : g_bad_width
      $error("popcnt31_tree: the tree is full at 31 inputs only");
   end
   if (OUT_W != PC_OUT_W) begin : g_bad_out
      $error("popcnt31_tree: output width mismatch");
   end

   // level 1: triples to 2-bit sums
   logic [1:0] l1 [PC_FA_N];
   for (genvar f = 0; f < PC_FA_N; f++) begin : g_l1
      popcnt_fa3 u_fa (
         .trio_i (bits_i[3*f +: 3]),
         .sum_o  (l1[f])
      );
   end

   // level 2: pairs of 2-bit sums plus one spare input
   logic [2:0] l2 [PC_L2_N];
   for (genvar p = 0; p < PC_L2_N; p++) begin : g_l2
      popcnt_rca #(.W(2)) u_add (
         .a_i   (l1[2*p]),
         .b_i   (l1[2*p+1]),
         .cin_i (bits_i[PC_L2_BASE + p]),
         .sum_o (l2[p])
      );
   end

   // level 3: pairs of 3-bit sums plus one spare input
   logic [3:0] l3 [PC_L3_N];
   for (genvar q = 0; q < PC_L3_N; q++) begin : g_l3
      popcnt_rca #(.W(3)) u_add (
         .a_i   (l2[2*q]),
         .b_i   (l2[2*q+1]),
         .cin_i (bits_i[PC_L3_BASE + q]),
         .sum_o (l3[q])
      );
   end

   // level 4: final 4-bit add, last input as carry-in
   logic [4:0] total;
   popcnt_rca #(.W(4)) u_final (
      .a_i   (l3[0]),
      .b_i   (l3[1]),
      .cin_i (bits_i[PC_L4_BIT]),
      .sum_o (total)
   );

   if (OUT_REG) begin : g_reg
      logic [4:0] count_q;
      always_ff @(posedge clk) begin
         if (!rst_n) count_q <= '0;
         else        count_q <= total;
      end
      assign count_o = count_q;

      // R5
      reset_clear_chk: assert property (@(posedge clk) !rst_n |=> count_o == 5'd0)
         else $error("output not cleared by reset");
      // R1
      pop_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> count_o == 5'($countones($past(bits_i))))
         else $error("registered count mismatch");
      // R3
      all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(&bits_i)) |-> count_o == 5'd31)
         else $error("all-ones input not counted as 31");
   end else begin : g_comb
      assign count_o = total;

      // R1
      always_comb begin
         pop_match_chk: assert (count_o == 5'($countones(bits_i)))
            else $error("direct count mismatch");
      end
      // R3
      all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (&bits_i) |-> count_o == 5'd31)
         else $error("all-ones input not counted as 31");
   end
endmodule

// File: tb/popcnt31_tree_tb.sv
module popcnt31_tree_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [30:0] bits;
   logic [4:0]  cnt_reg, cnt_dir;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   popcnt31_tree #(.OUT_REG(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .bits_i(bits), .count_o(cnt_reg));
   popcnt31_tree #(.OUT_REG(1'b0)) u_dut_comb (
      .clk(clk), .rst_n(rst_n), .bits_i(bits), .count_o(cnt_dir));

   function automatic int ref_count(input logic [30:0] v);
      int n = 0;
      for (int i = 0; i < 31; i++) if (v[i]) n++;
      return n;
   endfunction

   task automatic check(input string req, input int got, input int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // apply at negedge; direct output checked just after, registered at next negedge
   task automatic apply(input logic [30:0] v, input string req);
      int e;
      @(negedge clk);
      bits = v;
      e = ref_count(v);
      #1;
      check({req, " direct"}, int'(cnt_dir), e);
      @(negedge clk);
      check({req, " registered"}, int'(cnt_reg), e);
   endtask

   initial begin
      bits = '1;
      repeat (3) @(negedge clk);
      // R5: reset clears register despite all-ones input
      check("R5 reset", int'(cnt_reg), 0);
      rst_n = 1'b1;

      apply(31'h0, "R2 zero");
      apply('1, "R3 all-ones");

      for (int i = 0; i < 31; i++) apply(31'(1) << i, "R4 single bit");

      for (int k = 0; k <= 31; k++) begin
         logic [31:0] m;
         m = (k == 32) ? '1 : ((32'd1 << k) - 1);
         apply(m[30:0], "R6 low prefix");
         apply(~m[30:0], "R6 low zeros");
      end

      apply(31'h5555_5555, "R1 alternating a");
      apply(31'h2aaa_aaaa, "R1 alternating b");
      apply(31'h7f00_00ff, "R7 ends set");

      for (int r = 0; r < 3000; r++) apply(31'($urandom), "R1 random");

      done = 1'b1;
   end

   initial begin : watchdog
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule